// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block sits on the host side of an 8-bit serial analog-to-digital converter that has its own active-low convert-start line. When asked for a sample, it pulls the start line low to begin a conversion. It then waits out the converter's internally timed acquisition and conversion. After that it issues eight serial clock pulses and collects the result bits, most significant first. The assembled byte is registered and announced with a one-cycle strobe.

The conversion wait is derived from two parameters: the system clock frequency and the worst-case conversion time in nanoseconds. The wait is rounded up to whole system clocks. The serial clock is a divided system clock: it idles low and each phase lasts `SCLK_HALF` system clocks. The converter updates its data line on each falling serial-clock edge, so the controller samples on each rising edge. A request is taken only when the controller is idle.

Top module: `adc_readout`

## Requirements
- R1: After reset the start line `cnv_n_o` is high (1), `sclk_o` is low (0), `busy_o` and `valid_o` are low, and `data_o` is 0.
- R2: A request sampled high while idle drives `cnv_n_o` low and `busy_o` high at that same clock edge.
- R3: The first rising edge of `sclk_o` comes exactly `WAIT_CYC + SCLK_HALF` system clocks after `cnv_n_o` falls, where `WAIT_CYC` is ceil(`CLK_HZ` * `CONV_NS` / 1e9).
- R4: Each transaction gives exactly 8 `sclk_o` pulses. Each pulse is high for `SCLK_HALF` clocks, and consecutive rising edges are 2*`SCLK_HALF` clocks apart.
- R5: `sdata_i` is sampled at each rising `sclk_o` edge, and the first sample lands in bit 7 of `data_o` (MSB first).
- R6: At the edge where the eighth pulse falls, `valid_o` goes high for exactly one cycle, `cnv_n_o` returns high, and `busy_o` drops.
- R7: A request raised while `busy_o` is high is ignored: it produces no extra result, and the controller is idle after the current transaction ends.
- R8: `data_o` keeps the last result until the next completion.
- R9: `sclk_o` is low whenever `cnv_n_o` is high, and `cnv_n_o` stays low for the whole of a transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Sample request |
| busy_o | output | 1 | Transaction in progress |
| cnv_n_o | output | 1 | Converter start line, falling edge starts a conversion |
| sclk_o | output | 1 | Serial clock to converter |
| sdata_i | input | 1 | Serial data from converter |
| data_o | output | 8 | Last captured result |
| valid_o | output | 1 | One-cycle pulse when `data_o` updates |

## Verification
All 256 byte values are pushed through a behavioural converter model. The model holds its data line low until the conversion time has passed, and it moves to the next bit on each falling serial clock. A controller that samples before the conversion finishes reads zeros for high bits, so the sweep tells it apart from a correct one. A wrong bit order or an off-by-one capture scrambles values that are not palindromes, and the sweep catches those too. On every other value the bench raises an extra request during the wait. This separates a controller that ignores such a request from one that restarts or queues it. Edge-to-edge cycle counts on each transfer confirm the conversion wait and the serial clock shape.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_SHIFT = 2'd2
  } rd_state_e;
endpackage

// File: rtl/adc_rd_sclk.sv
module adc_rd_sclk #(
  parameter int HALF = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = $clog2(HALF + 1);
  localparam logic [CW-1:0] LD = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          sclk_q;
  logic          tick;

  assign tick   = run_i && (cnt_q == '0);
  assign rise_o = tick && !sclk_q;
  assign fall_o = tick && sclk_q;
  assign sclk_o = sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= LD;
      sclk_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= LD;
      sclk_q <= 1'b0;
    end else if (tick) begin
      cnt_q  <= LD;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  assert_sclk_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !sclk_q);
  assert_phase_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $changed(sclk_q)) |-> cnt_q == LD);
endmodule

// File: rtl/adc_rd_shreg.sv
module adc_rd_shreg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] word_o,
  output logic         full_o
);
  localparam int NW = $clog2(W + 1);

  logic [W-1:0]  word_q;
  logic [NW-1:0] num_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      num_q  <= '0;
    end else if (clr_i) begin
      num_q  <= '0;
    end else if (shift_i) begin
      word_q <= {word_q[W-2:0], bit_i};
      num_q  <= num_q + 1'b1;
    end
  end

  assign word_o = word_q;
  assign full_o = (num_q == NW'(W));

  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |-> !full_o);
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int WAIT_CYC = 1500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic fall_i,
  input  logic full_i,
  output logic busy_o,
  output logic cnv_n_o,
  output logic run_o,
  output logic clr_o,
  output logic done_o
);
  localparam int WW = $clog2(WAIT_CYC + 1);
  localparam logic [WW-1:0] WLD = WW'(WAIT_CYC - 1);

  rd_state_e     state_q, state_d;
  logic [WW-1:0] wcnt_q, wcnt_d;
  logic          cnv_n_q, cnv_n_d;
  logic          start;

  assign start  = (state_q == ST_IDLE) && req_i;
  assign done_o = (state_q == ST_SHIFT) && fall_i && full_i;
  assign clr_o  = start;
  assign run_o  = (state_q == ST_SHIFT);
  assign busy_o = (state_q != ST_IDLE);
  assign cnv_n_o = cnv_n_q;

  always_comb begin
    state_d = state_q;
    wcnt_d  = wcnt_q;
    cnv_n_d = cnv_n_q;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        state_d = ST_CONV;
        wcnt_d  = WLD;
        cnv_n_d = 1'b0;
      end
      ST_CONV: begin
        if (wcnt_q == '0) state_d = ST_SHIFT;
        else              wcnt_d  = wcnt_q - 1'b1;
      end
      ST_SHIFT: if (done_o) begin
        state_d = ST_IDLE;
        cnv_n_d = 1'b1;
      end
      default: begin
        state_d = ST_IDLE;
        cnv_n_d = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wcnt_q  <= '0;
      cnv_n_q <= 1'b1;
    end else begin
      state_q <= state_d;
      wcnt_q  <= wcnt_d;
      cnv_n_q <= cnv_n_d;
    end
  end

  assert_start_on_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cnv_n_q) |-> $past(req_i) && !$past(busy_o));
  assert_cnv_tracks_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o == !cnv_n_q);
  assert_busy_req_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONV && wcnt_q != '0) |=> state_q == ST_CONV);
endmodule

// File: rtl/adc_readout.sv
module adc_readout #(
  parameter int CLK_HZ    = 200_000_000,
  parameter int CONV_NS   = 7500,
  parameter int SCLK_HALF = 4,
  parameter int NBITS     = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  output logic             busy_o,
  output logic             cnv_n_o,
  output logic             sclk_o,
  input  logic             sdata_i,
  output logic [NBITS-1:0] data_o,
  output logic             valid_o
);
  localparam longint PROD   = longint'(CLK_HZ) * longint'(CONV_NS);
  localparam int WAIT_CYC   = int'((PROD + 64'd999_999_999) / 64'd1_000_000_000);

  logic             run, clr, done, rise, fall, full;
  logic [NBITS-1:0] word;
  logic [NBITS-1:0] data_q;
  logic             valid_q;

  adc_rd_ctrl #(.WAIT_CYC(WAIT_CYC)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .fall_i  (fall),
    .full_i  (full),
    .busy_o  (busy_o),
    .cnv_n_o (cnv_n_o),
    .run_o   (run),
    .clr_o   (clr),
    .done_o  (done)
  );

  adc_rd_sclk #(.HALF(SCLK_HALF)) u_sclk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .sclk_o (sclk_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  adc_rd_shreg #(.W(NBITS)) u_shreg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .shift_i (rise),
    .bit_i   (sdata_i),
    .word_o  (word),
    .full_o  (full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= done;
      if (done) data_q <= word;
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;

  assert_valid_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  assert_valid_at_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> cnv_n_o && !busy_o && !sclk_o);
  assert_data_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_q |-> $stable(data_q));
  assert_sclk_in_txn_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !cnv_n_o);
endmodule

// File: tb/tb_adc_readout.sv
`timescale 1ns/1ps
module tb_adc_readout;
  localparam int CLK_HZ  = 200_000_000;
  localparam int CONV_NS = 100;
  localparam int HALF    = 4;
  localparam int EXP_WAIT = (CLK_HZ / 1_000_000 * CONV_NS + 999) / 1000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0;
  logic       busy, cnv_n, sclk, valid;
  logic       sdo = 1'b0;
  logic [7:0] data;
  logic [7:0] sample = 8'h00;
  int         idx = 7;
  int         checks = 0;
  int         errors = 0;
  bit         finished = 1'b0;

  always #2.5 clk = ~clk;

  adc_readout #(.CLK_HZ(CLK_HZ), .CONV_NS(CONV_NS), .SCLK_HALF(HALF), .NBITS(8)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .busy_o(busy), .cnv_n_o(cnv_n),
    .sclk_o(sclk), .sdata_i(sdo), .data_o(data), .valid_o(valid)
  );

  // converter model: low during conversion, MSB after CONV_NS, next bit per sclk fall
  always @(negedge cnv_n) begin
    sdo = 1'b0;
    idx = 7;
    #(CONV_NS);
    sdo = sample[7];
  end
  always @(negedge sclk) begin
    if (idx > 0) begin
      idx = idx - 1;
      sdo = sample[idx];
    end else begin
      sdo = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] v, input bit poke);
    int c, first_rise, last_rise, rises, shape_err, cnv_err;
    logic prev;
    sample = v;
    @(negedge clk) req = 1'b1;
    @(negedge clk) req = 1'b0;
    chk(cnv_n == 1'b0 && busy == 1'b1, "R2 start", {cnv_n, busy}, 1);
    c = 0; first_rise = -1; last_rise = 0; rises = 0; shape_err = 0; cnv_err = 0;
    prev = sclk;
    while (!valid && c < 1000) begin
      @(negedge clk);
      c++;
      if (poke && c == 10) req = 1'b1;
      if (poke && c == 11) req = 1'b0;
      if (sclk && !prev) begin
        if (rises == 0) first_rise = c;
        else if (c - last_rise != 2 * HALF) shape_err++;
        last_rise = c;
        rises++;
      end
      if (!sclk && prev && !valid && c - last_rise != HALF) shape_err++;
      if (!valid && cnv_n) cnv_err++;
      prev = sclk;
    end
    chk(first_rise == EXP_WAIT + HALF, "R3 wait", first_rise, EXP_WAIT + HALF);
    chk(rises == 8, "R4 pulses", rises, 8);
    chk(shape_err == 0, "R4 shape", shape_err, 0);
    chk(data == v, "R5 data", data, v);
    chk(valid && cnv_n && !busy && !sclk, "R6 end", {valid, cnv_n, busy, sclk}, 4'b1100);
    chk(cnv_err == 0, "R9 cnv low", cnv_err, 0);
    @(negedge clk);
    chk(!valid, "R6 pulse", valid, 0);
    repeat (3) @(negedge clk);
    chk(!busy && cnv_n && !valid, "R7 idle after", {busy, cnv_n, valid}, 2'b10);
    chk(data == v, "R8 hold", data, v);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cnv_n && !sclk && !busy && !valid && data == 0, "R1 reset",
        {cnv_n, sclk, busy, valid}, 4'b1000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cnv_n && !sclk && !busy, "R1 idle", {cnv_n, sclk, busy}, 3'b100);
    for (int v = 0; v < 256; v++) xfer(8'(v), v[0]);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule